// File: doc/BRIEF.md
# Packed Audio Word Unpacker

The unpacker sits between a playback FIFO and a serial audio transmitter. The FIFO delivers 64-bit words, and each word carries a whole number of right-justified samples. On each request from the transmitter, the block picks the next lane out of the word it holds. It keeps only the configured number of valid bits and moves the sample so that its most significant bit sits at bit 27 of a 32-bit subframe word. The transmitter shifts that word out LSB first. The sample comes back one cycle after the request, together with the subframe slot (channel) it belongs to.

Software sets up the packing code, the MSB index and the channel mask through a small write-only register port, and then sets the enable bit. Stereo consumes one lane per subframe. Mono consumes one lane per frame and sends it in both subframes. A request that finds no word buffered produces a silent sample and sets a sticky underrun flag.

Top module: `awu_unpacker`

## Requirements
- R1: After reset, `fifo_ready`, `smp_ack` and `underrun` are 0.
- R2: `fifo_ready` is 1 only while the block is enabled and holds no word; a word is pulled on a cycle with `fifo_valid` and `fifo_ready` both 1, and the next word is pulled only after the last lane of the held word has been consumed.
- R3: Packing code 0 splits the word into eight 8-bit lanes, used from bits 7:0 upward.
- R4: Packing code 2 splits the word into four 16-bit lanes, used from bits 15:0 upward.
- R5: Packing code 4, and any code other than 0 and 2, splits the word into two 32-bit lanes, low half first.
- R6: The MSB index field `m` keeps lane bits m..0 and discards the rest; the kept value is shifted so that bit m lands at `smp_data` bit 27 (shifted right when m > 27); all other output bits are 0.
- R7: When mask bits 1:0 are both set, every request consumes a lane, and `smp_chan` alternates 0, 1, 0, ... starting from 0 after enable.
- R8: When exactly one of mask bits 1:0 is set, a request in slot 0 consumes a lane and the following slot-1 request returns the same sample again without consuming a lane.
- R9: A consuming request that finds no held word returns data 0 and sets `underrun`; the flag stays set until a write to address 1 with data bit 0 set (a new underrun in that cycle wins).
- R10: The control register at address 0 holds enable in bit 0, the packing code in bits 6:4, the MSB index in bits 12:8 and the channel mask in bits 23:16. The fields other than enable load only when the block is disabled before the write; writes made while the block is enabled change enable alone.
- R11: While the block is disabled, requests are acknowledged with data 0 and channel 0. The held word is dropped, and the slot counter returns to 0.
- R12: `smp_ack` is 1 in exactly the cycle after a cycle with `smp_req` high, and `smp_data`/`smp_chan` are valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 status) |
| reg_wdata | input | 32 | Register write data |
| fifo_valid | input | 1 | FIFO has a word |
| fifo_data | input | 64 | FIFO word |
| fifo_ready | output | 1 | Block takes the FIFO word this cycle |
| smp_req | input | 1 | Transmitter asks for the next subframe sample |
| smp_ack | output | 1 | Sample returned |
| smp_data | output | 32 | Aligned sample, MSB at bit 27 |
| smp_chan | output | 1 | Subframe slot of the sample |
| underrun | output | 1 | Sticky underrun flag |

## Verification
A wrong lane index shows on the very next acknowledge as the value of a neighbouring lane. It also shows as `fifo_ready` rising one request too early or too late. A slot counter out of step shows at once as a wrong `smp_chan`, and in mono as a fresh lane where a repeat was due. Loss of the held word on disable, or a configuration field that loads while enabled, shows on the first acknowledge after the change. The bench compares every port against its model on every clock, so any such fault is caught within one cycle of reaching an output.

// File: rtl/awu_pkg.sv
package awu_pkg;
  localparam int TYPE_W = 3;
  localparam int MSB_W  = 5;
  localparam int MASK_W = 8;

  localparam logic [TYPE_W-1:0] PACK_B8  = 3'd0;
  localparam logic [TYPE_W-1:0] PACK_B16 = 3'd2;

  localparam int EN_BIT   = 0;
  localparam int PACK_LSB = 4;
  localparam int MSB_LSB  = 8;
  localparam int MASK_LSB = 16;
  localparam int URUN_BIT = 0;

  localparam int CTRL_ADDR = 0;
  localparam int STAT_ADDR = 1;

  typedef struct packed {
    logic [TYPE_W-1:0] pack;
    logic [MSB_W-1:0]  msb;
    logic [MASK_W-1:0] mask;
  } cfg_t;
endpackage

// File: rtl/awu_cfg.sv
module awu_cfg #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              urun_set_i,
  output logic              en_o,
  output awu_pkg::cfg_t     cfg_o,
  output logic              urun_o
);
  import awu_pkg::*;

  logic en_q, en_d;
  cfg_t cfg_q, cfg_d;
  logic urun_q, urun_d;
  logic ctrl_wr, stat_clr;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_comb begin
    ctrl_wr  = wr_i && (addr_i == ADDR_W'(CTRL_ADDR));
    stat_clr = wr_i && (addr_i == ADDR_W'(STAT_ADDR)) && wdata_i[URUN_BIT];
    en_d  = en_q;
    cfg_d = cfg_q;
    if (ctrl_wr) begin
      en_d = wdata_i[EN_BIT];
      // fields are frozen while running
      if (!en_q) begin
        cfg_d.pack = wdata_i[PACK_LSB +: TYPE_W];
        cfg_d.msb  = wdata_i[MSB_LSB  +: MSB_W];
        cfg_d.mask = wdata_i[MASK_LSB +: MASK_W];
      end
    end
    urun_d = urun_set_i | (urun_q & ~stat_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      cfg_q  <= '0;
      urun_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      cfg_q  <= cfg_d;
      urun_q <= urun_d;
    end
  end

  assign en_o   = en_q;
  assign cfg_o  = cfg_q;
  assign urun_o = urun_q;
endmodule

// File: rtl/awu_wordbuf.sv
module awu_wordbuf #(
  parameter int WORD_W = 64,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              fifo_valid_i,
  input  logic [WORD_W-1:0] fifo_data_i,
  output logic              fifo_ready_o,
  input  logic              take_i,
  input  logic [IDX_W-1:0]  last_idx_i,
  output logic [WORD_W-1:0] word_o,
  output logic [IDX_W-1:0]  lane_o,
  output logic              have_o
);
  logic [WORD_W-1:0] word_q;
  logic              have_q, have_d;
  logic [IDX_W-1:0]  lane_q, lane_d;
  logic              load;

  assign fifo_ready_o = en_i & ~have_q;

  always_comb begin
    load   = fifo_ready_o & fifo_valid_i;
    have_d = have_q;
    lane_d = lane_q;
    if (!en_i) begin
      have_d = 1'b0;
      lane_d = '0;
    end else if (take_i && have_q) begin
      if (lane_q == last_idx_i) begin
        have_d = 1'b0;
        lane_d = '0;
      end else begin
        lane_d = lane_q + 1'b1;
      end
    end else if (load) begin
      have_d = 1'b1;
      lane_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      lane_q <= '0;
    end else begin
      have_q <= have_d;
      lane_q <= lane_d;
    end
  end

  // data register carries only a load enable
  always_ff @(posedge clk) begin
    if (load) word_q <= fifo_data_i;
  end

  assign word_o = word_q;
  assign lane_o = lane_q;
  assign have_o = have_q;
endmodule

// File: rtl/awu_lane_align.sv
module awu_lane_align #(
  parameter int WORD_W   = 64,
  parameter int SUB_W    = 32,
  parameter int MSB_SLOT = 27,
  parameter int IDX_W    = 3,
  parameter int MSB_W    = 5,
  parameter int TYPE_W   = 3
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [IDX_W-1:0]  lane_i,
  input  logic [TYPE_W-1:0] pack_i,
  input  logic [MSB_W-1:0]  msb_i,
  output logic [SUB_W-1:0]  sample_o
);
  localparam int NPACK = 3;

  logic [SUB_W-1:0] lane_val [NPACK];
  logic [SUB_W-1:0] picked, keep, kept;
  logic [MSB_W-1:0] sh;

  for (genvar p = 0; p < NPACK; p++) begin : g_pack
    localparam int LW  = 8 << p;
    localparam int NL  = WORD_W / LW;
    localparam int SW  = (NL > 1) ? $clog2(NL) : 1;
    logic [LW-1:0] lanes [NL];
    for (genvar l = 0; l < NL; l++) begin : g_lane
      assign lanes[l] = word_i[l*LW +: LW];
    end
    assign lane_val[p] = SUB_W'(lanes[lane_i[SW-1:0]]);
  end

  always_comb begin
    case (pack_i)
      awu_pkg::PACK_B8:  picked = lane_val[0];
      awu_pkg::PACK_B16: picked = lane_val[1];
      default:           picked = lane_val[2];
    endcase
    keep = ((SUB_W'(1) << msb_i) << 1) - SUB_W'(1);
    kept = picked & keep;
    if (msb_i <= MSB_W'(MSB_SLOT)) begin
      sh       = MSB_W'(MSB_SLOT) - msb_i;
      sample_o = kept << sh;
    end else begin
      sh       = msb_i - MSB_W'(MSB_SLOT);
      sample_o = kept >> sh;
    end
  end
endmodule

// File: rtl/awu_unpacker.sv
module awu_unpacker #(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 32,
  parameter int WORD_W   = 64,
  parameter int SUB_W    = 32,
  parameter int MSB_SLOT = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              fifo_valid,
  input  logic [WORD_W-1:0] fifo_data,
  output logic              fifo_ready,
  input  logic              smp_req,
  output logic              smp_ack,
  output logic [SUB_W-1:0]  smp_data,
  output logic              smp_chan,
  output logic              underrun
);
  import awu_pkg::*;

  localparam int IDX_W = $clog2(WORD_W / 8);
  localparam logic [IDX_W-1:0] LAST_B8  = IDX_W'(WORD_W / 8 - 1);
  localparam logic [IDX_W-1:0] LAST_B16 = IDX_W'(WORD_W / 16 - 1);
  localparam logic [IDX_W-1:0] LAST_B32 = IDX_W'(WORD_W / 32 - 1);

  logic              cfg_en;
  cfg_t              cfg;
  logic              urun_set;
  logic              have, take, consume, stereo, mono;
  logic [WORD_W-1:0] word;
  logic [IDX_W-1:0]  lane, last_idx;
  logic [SUB_W-1:0]  aligned, fresh;
  logic              ack_q, ack_d, slot_q, slot_d, chan_q, chan_d;
  logic [SUB_W-1:0]  data_q, data_d;
  logic              unused_mask_hi;

  assign unused_mask_hi = ^cfg.mask[MASK_W-1:2];

  awu_cfg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .urun_set_i(urun_set),
    .en_o(cfg_en), .cfg_o(cfg), .urun_o(underrun)
  );

  always_comb begin
    case (cfg.pack)
      PACK_B8:  last_idx = LAST_B8;
      PACK_B16: last_idx = LAST_B16;
      default:  last_idx = LAST_B32;
    endcase
  end

  awu_wordbuf #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .en_i(cfg_en),
    .fifo_valid_i(fifo_valid), .fifo_data_i(fifo_data), .fifo_ready_o(fifo_ready),
    .take_i(take), .last_idx_i(last_idx),
    .word_o(word), .lane_o(lane), .have_o(have)
  );

  awu_lane_align #(
    .WORD_W(WORD_W), .SUB_W(SUB_W), .MSB_SLOT(MSB_SLOT),
    .IDX_W(IDX_W), .MSB_W(MSB_W), .TYPE_W(TYPE_W)
  ) u_align (
    .word_i(word), .lane_i(lane), .pack_i(cfg.pack), .msb_i(cfg.msb),
    .sample_o(aligned)
  );

  always_comb begin
    stereo   = cfg.mask[0] & cfg.mask[1];
    mono     = cfg.mask[0] ^ cfg.mask[1];
    consume  = cfg_en & smp_req & (stereo | (mono & ~slot_q));
    take     = consume & have;
    urun_set = consume & ~have;
    fresh    = have ? aligned : '0;
    ack_d    = smp_req;
    slot_d   = slot_q;
    chan_d   = chan_q;
    data_d   = data_q;
    if (!cfg_en) slot_d = 1'b0;
    if (smp_req) begin
      if (!cfg_en) begin
        data_d = '0;
        chan_d = 1'b0;
      end else begin
        chan_d = slot_q;
        slot_d = ~slot_q;
        // mono slot 1 resends the sample still held in the output register
        if (consume)   data_d = fresh;
        else if (mono) data_d = data_q;
        else           data_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      slot_q <= 1'b0;
      chan_q <= 1'b0;
      data_q <= '0;
    end else begin
      ack_q  <= ack_d;
      slot_q <= slot_d;
      if (smp_req) begin
        chan_q <= chan_d;
        data_q <= data_d;
      end
    end
  end

  assign smp_ack  = ack_q;
  assign smp_data = data_q;
  assign smp_chan = chan_q;
endmodule

// File: rtl/awu_unpacker_chk.sv
module awu_unpacker_chk #(
  parameter int ADDR_W = 2,
  parameter int SUB_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wdata_b0,
  input logic              en,
  input logic              fifo_ready,
  input logic              smp_req,
  input logic              smp_ack,
  input logic [SUB_W-1:0]  smp_data,
  input logic              underrun
);
  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    smp_req |=> smp_ack);                                                  // R12
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_req |=> !smp_ack);                                                // R12
  AST_HIGH_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ack |-> (smp_data[SUB_W-1:28] == '0));                             // R6
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !(reg_wr && reg_addr == ADDR_W'(1) && reg_wdata_b0)) |=> underrun); // R9
  AST_UNDERRUN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> (smp_ack && smp_data == '0));                      // R9
  AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready |-> en);                                                    // R2
endmodule

bind awu_unpacker awu_unpacker_chk #(.ADDR_W(ADDR_W), .SUB_W(SUB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata_b0(reg_wdata[0]), .en(cfg_en), .fifo_ready(fifo_ready),
  .smp_req(smp_req), .smp_ack(smp_ack), .smp_data(smp_data), .underrun(underrun)
);

// File: tb/awu_unpacker_bench.sv
module awu_unpacker_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        fifo_valid;
  logic [63:0] fifo_data;
  logic        fifo_ready;
  logic        smp_req;
  logic        smp_ack;
  logic [31:0] smp_data;
  logic        smp_chan;
  logic        underrun;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  awu_unpacker u_awu_unpacker (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
    .fifo_ready(fifo_ready), .smp_req(smp_req), .smp_ack(smp_ack),
    .smp_data(smp_data), .smp_chan(smp_chan), .underrun(underrun)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic expect_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    chk(act == exp, tag, act, exp);
  endtask

  // ---------------- reference model ----------------
  logic [63:0] q[$];
  bit          m_en, m_bufv, m_slot, m_urun, m_ack, m_chan;
  int          m_type, m_msb, m_mask, m_lane;
  logic [63:0] m_word;
  logic [31:0] m_data;

  function automatic int lane_w(input int typ);
    if (typ == 0) return 8;
    if (typ == 2) return 16;
    return 32;
  endfunction

  function automatic logic [31:0] ref_sample(input logic [63:0] w, input int lane, input int typ, input int msb);
    int lw;
    logic [63:0] v;
    lw = lane_w(typ);
    v  = (w >> (lane * lw)) & ((64'd1 << lw) - 64'd1);
    v  = v & ((64'd1 << (msb + 1)) - 64'd1);
    if (msb <= 27) v = v << (27 - msb);
    else           v = v >> (msb - 27);
    return v[31:0];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_bufv = 0; m_slot = 0; m_urun = 0; m_ack = 0; m_chan = 0;
      m_type = 0; m_msb = 0; m_mask = 0; m_lane = 0; m_data = '0;
      q.delete();
    end else begin
      bit en0, bufv0, uset, uclr;
      int nch;
      en0 = m_en; bufv0 = m_bufv; uset = 0;
      m_ack = smp_req;
      if (smp_req) begin
        if (!en0) begin
          m_data = '0; m_chan = 0;
        end else begin
          bit cons;
          nch  = (m_mask & 1) + ((m_mask >> 1) & 1);
          cons = (nch == 2) || (nch == 1 && !m_slot);
          m_chan = m_slot;
          if (cons) begin
            if (bufv0) begin
              m_data = ref_sample(m_word, m_lane, m_type, m_msb);
              m_lane++;
              if (m_lane == 64 / lane_w(m_type)) begin m_bufv = 0; m_lane = 0; end
            end else begin
              m_data = '0; uset = 1;
            end
          end else if (nch != 1) begin
            m_data = '0;
          end
          m_slot = !m_slot;
        end
      end
      if (!en0) begin m_bufv = 0; m_lane = 0; m_slot = 0; end
      else if (!bufv0 && q.size() > 0) begin
        m_word = q.pop_front(); m_bufv = 1; m_lane = 0;
      end
      uclr = reg_wr && reg_addr == 2'd1 && reg_wdata[0];
      m_urun = uset || (m_urun && !uclr);
      if (reg_wr && reg_addr == 2'd0) begin
        m_en = reg_wdata[0];
        if (!en0) begin
          m_type = int'(reg_wdata[6:4]);
          m_msb  = int'(reg_wdata[12:8]);
          m_mask = int'(reg_wdata[23:16]);
        end
      end
    end
  end

  // drive FIFO side from the queue just after each falling edge
  always @(negedge clk) begin
    #1;
    fifo_valid = (q.size() > 0);
    fifo_data  = (q.size() > 0) ? q[0] : 64'd0;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      expect_eq("R2 fifo_ready", {63'd0, fifo_ready}, {63'd0, (m_en && !m_bufv)});
      expect_eq("R12 smp_ack", {63'd0, smp_ack}, {63'd0, m_ack});
      if (smp_ack) begin
        expect_eq("R6 smp_data", {32'd0, smp_data}, {32'd0, m_data});
        expect_eq("R7 smp_chan", {63'd0, smp_chan}, {63'd0, m_chan});
      end
      expect_eq("R9 underrun", {63'd0, underrun}, {63'd0, m_urun});
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [31:0] ctrl(input bit en, input int typ, input int msb, input int mask);
    return {8'd0, 8'(mask), 3'd0, 5'(msb), 1'b0, 3'(typ), 3'd0, en};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic push(input logic [63:0] w);
    q.push_back(w);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_req(output logic [31:0] d, output logic c);
    @(negedge clk);
    smp_req = 1;
    @(negedge clk);
    smp_req = 0;
    d = smp_data;
    c = smp_chan;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic        c;
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; smp_req = 0;
    fifo_valid = 0; fifo_data = 0;
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    expect_eq("R1 fifo_ready", {63'd0, fifo_ready}, 64'd0);
    expect_eq("R1 smp_ack", {63'd0, smp_ack}, 64'd0);
    expect_eq("R1 underrun", {63'd0, underrun}, 64'd0);

    // R5 / R7: two 32-bit lanes, 24-bit samples, stereo
    wr(2'd0, ctrl(1, 4, 23, 3));
    push(64'h0012_3456_00AB_CDEF);
    idle(3);
    do_req(d, c);
    expect_eq("R5 lane0 data", {32'd0, d}, 64'h0ABC_DEF0);
    expect_eq("R7 lane0 chan", {63'd0, c}, 64'd0);
    expect_eq("R2 ready held mid-word", {63'd0, fifo_ready}, 64'd0);
    do_req(d, c);
    expect_eq("R5 lane1 data", {32'd0, d}, 64'h0123_4560);
    expect_eq("R7 lane1 chan", {63'd0, c}, 64'd1);
    expect_eq("R2 ready after last lane", {63'd0, fifo_ready}, 64'd1);

    // R4: four 16-bit lanes
    wr(2'd0, 32'd0);
    wr(2'd0, ctrl(1, 2, 15, 3));
    push(64'h4444_3333_2222_1111);
    idle(3);
    for (int i = 1; i <= 4; i++) begin
      do_req(d, c);
      expect_eq("R4 16-bit lane", {32'd0, d}, 64'(i * 32'h0111_1000));
    end

    // R3 / R8 / R10: eight 8-bit lanes, mono, ignored write while enabled
    wr(2'd0, 32'd0);
    wr(2'd0, ctrl(1, 0, 7, 1));
    wr(2'd0, ctrl(1, 4, 23, 3));
    push(64'h8877_6655_4433_2211);
    idle(3);
    do_req(d, c);
    expect_eq("R10 fields kept, R3 lane0", {32'd0, d}, 64'h0110_0000);
    do_req(d, c);
    expect_eq("R8 mono repeat data", {32'd0, d}, 64'h0110_0000);
    expect_eq("R8 mono repeat chan", {63'd0, c}, 64'd1);
    do_req(d, c);
    expect_eq("R3 lane1", {32'd0, d}, 64'h0220_0000);

    // R11: disabled requests, word dropped
    wr(2'd0, 32'd0);
    do_req(d, c);
    expect_eq("R11 disabled data", {32'd0, d}, 64'd0);
    expect_eq("R11 disabled chan", {63'd0, c}, 64'd0);
    expect_eq("R11 not ready", {63'd0, fifo_ready}, 64'd0);
    wr(2'd0, ctrl(1, 0, 7, 1));
    do_req(d, c);
    expect_eq("R11 word dropped, R9 silent", {32'd0, d}, 64'd0);
    expect_eq("R9 underrun set", {63'd0, underrun}, 64'd1);
    wr(2'd1, 32'd0);
    idle(2);
    expect_eq("R9 sticky", {63'd0, underrun}, 64'd1);
    wr(2'd1, 32'd1);
    expect_eq("R9 cleared", {63'd0, underrun}, 64'd0);

    // R6: 20-bit samples with garbage above, and MSB above slot 27
    wr(2'd0, 32'd0);
    wr(2'd0, ctrl(1, 4, 19, 3));
    push(64'h8000_0001_FFFF_FFFF);
    idle(3);
    do_req(d, c);
    expect_eq("R6 20-bit full", {32'd0, d}, 64'h0FFF_FF00);
    do_req(d, c);
    expect_eq("R6 20-bit trimmed", {32'd0, d}, 64'h0000_0100);
    wr(2'd0, 32'd0);
    wr(2'd0, ctrl(1, 7, 31, 3));
    push(64'h0000_0010_8000_0001);
    idle(3);
    do_req(d, c);
    expect_eq("R6 R5 msb31 lane0", {32'd0, d}, 64'h0800_0000);
    do_req(d, c);
    expect_eq("R6 R5 msb31 lane1", {32'd0, d}, 64'h0000_0001);
    idle(3);
    finish_run();
  end
endmodule